// File: doc/BRIEF.md
# Cartridge Bank Register Address Translator

This block holds the bank-select registers of a game-cartridge memory mapper and turns bus addresses into memory addresses on both sides of the console. The processor programs the registers with writes into the upper half of its 64 KB space. The registers then steer processor reads to 8 KB pages of program ROM. On the picture-processor side, each 1 KB pattern slot and each 1 KB nametable slot can be pointed at pattern ROM, at an 8 KB on-cartridge pattern RAM, or at one of the console's two internal 1 KB RAM pages.

A bank number of $E0 or above is the reserved range. It sends a nametable slot to console RAM, with bank bit 0 picking the page. It sends a pattern slot to pattern RAM, with bank bits 2..0 picking the 1 KB page, but only while the gate bit for that 4 KB pattern half is enabled. Address translation is purely combinational from the registered state. Writes land on the clock edge that samples the strobe. The ROM sizes are parameters given as log2 of their size in KB, and the bank masks are derived from them.

Top module: `cart_bank_xlate`

## Requirements
- R1: A processor write is decoded from cpu_addr[15:11] only. Bit 15 must be 1, so each register owns a 2 KB window and bits 10..0 of the address do not matter.
- R2: Windows 0..7 (cpu_addr[14:11] = 0..7, $8000–$BFFF) load the pattern bank of slots 0..7 in that order. Each value is ANDed with the pattern bank mask (2^CHR_KB_LOG2 − 1).
- R3: Windows 8..11 ($C000, $C800, $D000, $D800) load nametable slot banks 0..3 with the full 8-bit value.
- R4: Windows 12, 13 and 14 ($E000, $E800, $F000) load program banks 0, 1 and 2 from cpu_data[5:0], masked to 2^(PRG_KB_LOG2−3) − 1. A read with cpu_addr[14:13] = n uses bank n. For n = 3 it always uses the last bank (all ones). prg_rom_addr = {bank, cpu_addr[12:0]}.
- R5: A write to window 13 also sets the pattern-RAM gates. cpu_data[6] = 1 disables RAM for the lower pattern half (ppu_addr[12] = 0), and cpu_data[7] = 1 disables it for the upper half.
- R6: For a pattern fetch (ppu_addr[13] = 0), a slot bank ≥ $E0 whose half is enabled selects pattern RAM (tgt_pat_ram = 1). The RAM address is {bank[2:0], ppu_addr[9:0]}.
- R7: Any other pattern fetch selects pattern ROM (tgt_pat_rom = 1) at {bank, ppu_addr[9:0]}.
- R8: For a nametable access (ppu_addr[13] = 1, slot = ppu_addr[11:10]), a bank ≥ $E0 selects console RAM (tgt_con_ram = 1) at {bank[0], ppu_addr[9:0]}. A lower bank selects pattern ROM at {bank, ppu_addr[9:0]}. Exactly one target flag is high at any time.
- R9: ppu_wr_en follows ppu_wr when the target is pattern RAM or console RAM. It is 0 whenever the target is pattern ROM, so writes there are ignored.
- R10: Reset sets all four nametable banks to $FF, all pattern and program banks to 0, and both pattern-RAM gates to enabled.
- R11: Register writes are visible only after the clock edge that samples cpu_wr. Translated outputs do not change while no write occurs and the addresses stay the same. Writes with cpu_addr[15] = 0 or to window 15 ($F800) change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | Processor address |
| cpu_data | input | 8 | Processor write data |
| cpu_wr | input | 1 | Processor write strobe |
| prg_rom_addr | output | PRG_KB_LOG2+10 | Program ROM byte address |
| ppu_addr | input | 14 | Picture-processor address |
| ppu_wr | input | 1 | Picture-processor write strobe |
| tgt_pat_rom | output | 1 | Access targets pattern ROM |
| tgt_pat_ram | output | 1 | Access targets pattern RAM |
| tgt_con_ram | output | 1 | Access targets console internal RAM |
| pat_rom_addr | output | CHR_KB_LOG2+10 | Pattern ROM byte address |
| pat_ram_addr | output | 13 | Pattern RAM byte address |
| con_ram_addr | output | 11 | Console RAM address, bit 10 is the page |
| ppu_wr_en | output | 1 | Write enable to the selected RAM |

## Verification
The hardest case to reach is a pattern slot holding a reserved bank while its half's gate is off. Reaching it needs a pattern write and a separately timed window-13 write with the right bits 7..6, followed by a fetch in that half. The bench writes this combination directly for each half. Its random phase biases about half of the data values into the $E0–$FF range and spreads writes over all sixteen windows with random low address bits. This makes gate/bank mixes and re-decoded windows frequent, and every fetch is compared against a register model kept in the bench.

// File: rtl/cbx_pkg.sv
package cbx_pkg;
    // First bank number of the reserved range that redirects a slot to RAM
    localparam logic [7:0] RSV_BANK_BASE = 8'hE0;
    // Register window indices (cpu_addr[14:11])
    localparam logic [3:0] WIN_NT_FIRST  = 4'd8;
    localparam logic [3:0] WIN_PRG0      = 4'd12;
    localparam logic [3:0] WIN_PRG1_GATE = 4'd13;
    localparam logic [3:0] WIN_PRG2      = 4'd14;

    function automatic logic is_rsv_bank(input logic [7:0] b);
        return b >= RSV_BANK_BASE;
    endfunction
endpackage

// File: rtl/cbx_regs.sv
module cbx_regs #(
    parameter int PRG_BANK_W = 5,
    parameter int CHR_BANK_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [15:11]               wr_win,
    input  logic [7:0]                 wr_data,
    input  logic                       wr_stb,
    output logic [7:0][7:0]            pat_bank,
    output logic [3:0][7:0]            nt_bank,
    output logic [2:0][PRG_BANK_W-1:0] prg_bank,
    output logic [1:0]                 ram_en
);
    import cbx_pkg::*;

    localparam logic [7:0]            CHR_MASK = 8'((1 << CHR_BANK_W) - 1);
    localparam logic [PRG_BANK_W-1:0] PRG_ONES = '1;

    typedef struct packed {
        logic [7:0][7:0]            pat;
        logic [3:0][7:0]            nt;
        logic [2:0][PRG_BANK_W-1:0] prg;
        logic [1:0]                 ram_en;
    } bank_regs_t;

    bank_regs_t regs_d, regs_q;
    logic [3:0] win;
    logic [PRG_BANK_W-1:0] prg_val;

    assign win     = wr_win[14:11];
    assign prg_val = PRG_BANK_W'(wr_data[5:0]) & PRG_ONES;

    always_comb begin
        regs_d = regs_q;
        if (wr_stb && wr_win[15]) begin
            if (win < WIN_NT_FIRST) begin
                regs_d.pat[win[2:0]] = wr_data & CHR_MASK;
            end else if (win < WIN_PRG0) begin
                regs_d.nt[win[1:0]] = wr_data;
            end else begin
                case (win)
                    WIN_PRG0: regs_d.prg[0] = prg_val;
                    WIN_PRG1_GATE: begin
                        regs_d.prg[1]    = prg_val;
                        regs_d.ram_en[0] = ~wr_data[6];
                        regs_d.ram_en[1] = ~wr_data[7];
                    end
                    WIN_PRG2: regs_d.prg[2] = prg_val;
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q.pat    <= '0;
            regs_q.nt     <= {4{8'hFF}};
            regs_q.prg    <= '0;
            regs_q.ram_en <= 2'b11;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign pat_bank = regs_q.pat;
    assign nt_bank  = regs_q.nt;
    assign prg_bank = regs_q.prg;
    assign ram_en   = regs_q.ram_en;
endmodule

// File: rtl/cbx_cpu_map.sv
module cbx_cpu_map #(
    parameter int PRG_BANK_W = 5
) (
    input  logic [14:0]                  cpu_addr,
    input  logic [2:0][PRG_BANK_W-1:0]   prg_bank,
    output logic [PRG_BANK_W+12:0]       rom_addr
);
    logic [PRG_BANK_W-1:0] bank;

    always_comb begin
        case (cpu_addr[14:13])
            2'd0:    bank = prg_bank[0];
            2'd1:    bank = prg_bank[1];
            2'd2:    bank = prg_bank[2];
            default: bank = '1;
        endcase
    end

    assign rom_addr = {bank, cpu_addr[12:0]};
endmodule

// File: rtl/cbx_ppu_map.sv
module cbx_ppu_map #(
    parameter int CHR_BANK_W = 8
) (
    input  logic [13:0]              ppu_addr,
    input  logic                     ppu_wr,
    input  logic [7:0][7:0]          pat_bank,
    input  logic [3:0][7:0]          nt_bank,
    input  logic [1:0]               ram_en,
    output logic                     tgt_pat_rom,
    output logic                     tgt_pat_ram,
    output logic                     tgt_con_ram,
    output logic [CHR_BANK_W+9:0]    pat_rom_addr,
    output logic [12:0]              pat_ram_addr,
    output logic [10:0]              con_ram_addr,
    output logic                     ppu_wr_en
);
    import cbx_pkg::*;

    logic       is_nt;
    logic [7:0] bank;
    logic       rsv;

    assign is_nt = ppu_addr[13];
    assign bank  = is_nt ? nt_bank[ppu_addr[11:10]] : pat_bank[ppu_addr[12:10]];
    assign rsv   = is_rsv_bank(bank);

    assign tgt_pat_ram = !is_nt && rsv && ram_en[ppu_addr[12]];
    assign tgt_con_ram = is_nt && rsv;
    assign tgt_pat_rom = !(tgt_pat_ram || tgt_con_ram);

    assign pat_rom_addr = {bank[CHR_BANK_W-1:0], ppu_addr[9:0]};
    assign pat_ram_addr = {bank[2:0], ppu_addr[9:0]};
    assign con_ram_addr = {bank[0], ppu_addr[9:0]};
    assign ppu_wr_en    = ppu_wr && !tgt_pat_rom;
endmodule

// File: rtl/cart_bank_xlate.sv
module cart_bank_xlate #(
    parameter int PRG_KB_LOG2 = 8,
    parameter int CHR_KB_LOG2 = 8,
    localparam int PRG_AW = PRG_KB_LOG2 + 10,
    localparam int CHR_AW = CHR_KB_LOG2 + 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       cpu_addr,
    input  logic [7:0]        cpu_data,
    input  logic              cpu_wr,
    output logic [PRG_AW-1:0] prg_rom_addr,
    input  logic [13:0]       ppu_addr,
    input  logic              ppu_wr,
    output logic              tgt_pat_rom,
    output logic              tgt_pat_ram,
    output logic              tgt_con_ram,
    output logic [CHR_AW-1:0] pat_rom_addr,
    output logic [12:0]       pat_ram_addr,
    output logic [10:0]       con_ram_addr,
    output logic              ppu_wr_en
);
    localparam int PRG_BANK_W = PRG_KB_LOG2 - 3;
    localparam int CHR_BANK_W = CHR_KB_LOG2;

    logic [7:0][7:0]            pat_bank;
    logic [3:0][7:0]            nt_bank;
    logic [2:0][PRG_BANK_W-1:0] prg_bank;
    logic [1:0]                 ram_en;

    cbx_regs #(.PRG_BANK_W(PRG_BANK_W), .CHR_BANK_W(CHR_BANK_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_win(cpu_addr[15:11]), .wr_data(cpu_data), .wr_stb(cpu_wr),
        .pat_bank(pat_bank), .nt_bank(nt_bank), .prg_bank(prg_bank), .ram_en(ram_en)
    );

    cbx_cpu_map #(.PRG_BANK_W(PRG_BANK_W)) u_cpu (
        .cpu_addr(cpu_addr[14:0]), .prg_bank(prg_bank), .rom_addr(prg_rom_addr)
    );

    cbx_ppu_map #(.CHR_BANK_W(CHR_BANK_W)) u_ppu (
        .ppu_addr(ppu_addr), .ppu_wr(ppu_wr),
        .pat_bank(pat_bank), .nt_bank(nt_bank), .ram_en(ram_en),
        .tgt_pat_rom(tgt_pat_rom), .tgt_pat_ram(tgt_pat_ram), .tgt_con_ram(tgt_con_ram),
        .pat_rom_addr(pat_rom_addr), .pat_ram_addr(pat_ram_addr),
        .con_ram_addr(con_ram_addr), .ppu_wr_en(ppu_wr_en)
    );
endmodule

// File: rtl/cbx_checker.sv
module cbx_checker #(
    parameter int PRG_AW = 18,
    parameter int CHR_AW = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic [15:0]       cpu_addr,
    input logic              cpu_wr,
    input logic [PRG_AW-1:0] prg_rom_addr,
    input logic [13:0]       ppu_addr,
    input logic              ppu_wr,
    input logic              tgt_pat_rom,
    input logic              tgt_pat_ram,
    input logic              tgt_con_ram,
    input logic [CHR_AW-1:0] pat_rom_addr,
    input logic [12:0]       pat_ram_addr,
    input logic [10:0]       con_ram_addr,
    input logic              ppu_wr_en
);
    assert_one_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({tgt_pat_rom, tgt_pat_ram, tgt_con_ram}));

    assert_last_bank_fixed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[14:13] == 2'b11) |-> (&prg_rom_addr[PRG_AW-1:13]));

    assert_prg_offset_R4: assert property (@(posedge clk) disable iff (!rst_n)
        prg_rom_addr[12:0] == cpu_addr[12:0]);

    assert_rom_write_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_pat_rom |-> !ppu_wr_en);

    assert_ram_write_passes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!tgt_pat_rom && ppu_wr) |-> ppu_wr_en);

    assert_con_ram_only_nt_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_con_ram |-> (ppu_addr[13] && con_ram_addr[9:0] == ppu_addr[9:0]));

    assert_pat_ram_only_pattern_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_pat_ram |-> (!ppu_addr[13] && pat_ram_addr[9:0] == ppu_addr[9:0]));

    assert_hold_without_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(cpu_wr) && $stable(cpu_addr) && $stable(ppu_addr)) |->
        ($stable(prg_rom_addr) && $stable(pat_rom_addr) && $stable(pat_ram_addr)
         && $stable(con_ram_addr) && $stable(tgt_pat_ram) && $stable(tgt_con_ram)));
endmodule

bind cart_bank_xlate cbx_checker #(.PRG_AW(PRG_AW), .CHR_AW(CHR_AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
    .prg_rom_addr(prg_rom_addr), .ppu_addr(ppu_addr), .ppu_wr(ppu_wr),
    .tgt_pat_rom(tgt_pat_rom), .tgt_pat_ram(tgt_pat_ram), .tgt_con_ram(tgt_con_ram),
    .pat_rom_addr(pat_rom_addr), .pat_ram_addr(pat_ram_addr),
    .con_ram_addr(con_ram_addr), .ppu_wr_en(ppu_wr_en)
);

// File: tb/sim_cart_bank_xlate.sv
`timescale 1ns/1ps
module sim_cart_bank_xlate;
    localparam int PRG_KB_LOG2 = 8;
    localparam int CHR_KB_LOG2 = 8;
    localparam int PRG_AW = PRG_KB_LOG2 + 10;
    localparam int CHR_AW = CHR_KB_LOG2 + 10;
    localparam int PRG_BW = PRG_KB_LOG2 - 3;
    localparam logic [7:0] CHR_MASK = 8'((1 << CHR_KB_LOG2) - 1);
    localparam logic [5:0] PRG_MASK = 6'((1 << PRG_BW) - 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_data = '0;
    logic        cpu_wr = 1'b0;
    logic [13:0] ppu_addr = '0;
    logic        ppu_wr = 1'b0;
    logic [PRG_AW-1:0] prg_rom_addr;
    logic tgt_pat_rom, tgt_pat_ram, tgt_con_ram, ppu_wr_en;
    logic [CHR_AW-1:0] pat_rom_addr;
    logic [12:0] pat_ram_addr;
    logic [10:0] con_ram_addr;

    always #2.5 clk = ~clk;

    cart_bank_xlate #(.PRG_KB_LOG2(PRG_KB_LOG2), .CHR_KB_LOG2(CHR_KB_LOG2)) u0 (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data), .cpu_wr(cpu_wr),
        .prg_rom_addr(prg_rom_addr), .ppu_addr(ppu_addr), .ppu_wr(ppu_wr),
        .tgt_pat_rom(tgt_pat_rom), .tgt_pat_ram(tgt_pat_ram), .tgt_con_ram(tgt_con_ram),
        .pat_rom_addr(pat_rom_addr), .pat_ram_addr(pat_ram_addr),
        .con_ram_addr(con_ram_addr), .ppu_wr_en(ppu_wr_en)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Bench register model, built from the requirements
    logic [7:0] m_pat [8];
    logic [7:0] m_nt  [4];
    logic [5:0] m_prg [3];
    logic [1:0] m_en;

    task automatic model_reset();
        for (int i = 0; i < 8; i++) m_pat[i] = 8'h00;
        for (int i = 0; i < 4; i++) m_nt[i] = 8'hFF;
        for (int i = 0; i < 3; i++) m_prg[i] = 6'h00;
        m_en = 2'b11;
    endtask

    task automatic model_write(input logic [15:0] a, input logic [7:0] d);
        int w;
        w = int'(a[14:11]);
        if (!a[15]) return;  // R1 / R11: only the upper half
        if (w < 8) m_pat[w] = d & CHR_MASK;           // R2
        else if (w < 12) m_nt[w - 8] = d;             // R3
        else if (w == 12) m_prg[0] = d[5:0] & PRG_MASK; // R4
        else if (w == 13) begin
            m_prg[1] = d[5:0] & PRG_MASK;
            m_en = {~d[7], ~d[6]};                    // R5
        end else if (w == 14) m_prg[2] = d[5:0] & PRG_MASK;
    endtask

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h exp %h", req, got, exp);
        end
    endtask

    task automatic chk_cpu(input logic [15:0] a, input string req);
        logic [5:0] b;
        logic [31:0] e;
        cpu_addr = a;
        #0.5;
        b = (a[14:13] == 2'd3) ? PRG_MASK : m_prg[a[14:13]];
        e = 32'({b[PRG_BW-1:0], a[12:0]});
        check(req, 32'(prg_rom_addr), e);
    endtask

    task automatic chk_ppu(input logic [13:0] a, input logic w, input string req);
        logic [7:0] b;
        logic [2:0] tg;
        logic [31:0] ea, ga;
        ppu_addr = a;
        ppu_wr = w;
        #0.5;
        b = a[13] ? m_nt[a[11:10]] : m_pat[a[12:10]];
        if (a[13] && b >= 8'hE0) begin
            tg = 3'b001; ea = 32'({b[0], a[9:0]});        // R8
            ga = 32'(con_ram_addr);
        end else if (!a[13] && b >= 8'hE0 && m_en[a[12]]) begin
            tg = 3'b010; ea = 32'({b[2:0], a[9:0]});      // R6
            ga = 32'(pat_ram_addr);
        end else begin
            tg = 3'b100; ea = 32'({b[CHR_KB_LOG2-1:0], a[9:0]}); // R7
            ga = 32'(pat_rom_addr);
        end
        check({req, " target"}, 32'({tgt_pat_rom, tgt_pat_ram, tgt_con_ram}), 32'(tg));
        check({req, " addr"}, ga, ea);
        check("R9 write enable", 32'(ppu_wr_en), 32'(w && tg != 3'b100));
    endtask

    task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_data = d; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
        model_write(a, d);
    endtask

    task automatic sweep(input string req);
        for (int s = 0; s < 8; s++) chk_ppu({1'b0, 3'(s), 10'($urandom)}, 1'($urandom), req);
        for (int s = 0; s < 4; s++) chk_ppu({1'b1, 1'($urandom), 2'(s), 10'($urandom)}, 1'($urandom), req);
        for (int s = 0; s < 4; s++) chk_cpu({1'b1, 2'(s), 13'($urandom)}, req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R11 got timeout exp completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7391));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: reset contents seen through the translation
        sweep("R10 reset");
        rst_n = 1'b1;
        @(negedge clk);
        sweep("R10 after reset");

        // R11: writes outside the register space, or to window 15, do nothing
        cpu_write(16'h0000, 8'hE5);
        cpu_write(16'h4C00, 8'hE1);
        cpu_write(16'hF8AB, 8'h3F);
        sweep("R11 ignored write");

        // R11: value not visible before the edge, visible after it
        @(negedge clk);
        cpu_addr = 16'h9000; cpu_data = 8'h33; cpu_wr = 1'b1;
        chk_ppu(14'h0812, 1'b0, "R11 before edge");
        @(negedge clk);
        cpu_wr = 1'b0;
        model_write(16'h9000, 8'h33);
        chk_ppu(14'h0812, 1'b0, "R11 after edge R2");

        // R1: low address bits are ignored in the decode
        cpu_write(16'h87FF, 8'hE6);
        chk_ppu(14'h0004, 1'b1, "R1 R6 slot0 ram");

        // R5: gate bits per half
        cpu_write(16'hA123, 8'hE5);                     // slot4
        cpu_write(16'hE800, 8'h41);                     // lower off, upper on
        chk_ppu(14'h0004, 1'b1, "R5 lower gated R7");
        chk_ppu(14'h1155, 1'b1, "R5 upper open R6");
        cpu_write(16'hEFFF, 8'h82);                     // lower on, upper off
        chk_ppu(14'h0004, 1'b0, "R5 lower open R6");
        chk_ppu(14'h1155, 1'b1, "R5 upper gated R7");

        // R4: data bits 7:6 ignored and mask applied; fixed last slot
        cpu_write(16'hE000, 8'hFF);
        chk_cpu(16'h8ABC, "R4 masked bank");
        cpu_write(16'hF7FF, 8'hC3);
        chk_cpu(16'hC001, "R4 slot2");
        chk_cpu(16'hFFFF, "R4 fixed last");

        // R3 / R8: nametable slots, unmasked; ROM fallback and page select
        cpu_write(16'hC000, 8'h5A);
        cpu_write(16'hC800, 8'hE0);
        cpu_write(16'hD7FF, 8'hDF);
        chk_ppu(14'h2010, 1'b1, "R3 R8 nt rom");
        chk_ppu(14'h2410, 1'b1, "R8 nt page0");
        chk_ppu(14'h2BFF, 1'b1, "R8 nt below range");
        chk_ppu(14'h3C01, 1'b1, "R8 nt mirror page1");

        // Random phase
        for (int it = 0; it < 3000; it++) begin
            int k;
            k = int'($urandom % 4);
            if (k == 0) begin
                logic [15:0] a;
                logic [7:0] d;
                a = 16'($urandom);
                if (($urandom % 8) != 0) a[15] = 1'b1;
                d = ($urandom % 2) ? (8'hE0 | 8'($urandom)) : 8'($urandom);
                cpu_write(a, d);
            end else if (k == 1) begin
                chk_cpu(16'($urandom), "R4 random");
            end else begin
                chk_ppu(14'($urandom), 1'($urandom), "R6 R7 R8 random");
            end
        end
        sweep("R2 R3 final");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule